// File: doc/BRIEF.md
# Byte-Lane Data Bus Inversion Codec

This block sits between a memory controller and its PHY and handles data bus inversion for every byte lane of every phase in a controller clock. On the write side it decides, lane by lane, whether to send the byte as it is or bit-flipped. It drives one active-low flag per lane that tells the far end which choice was made. On the read side it takes received bytes and their flags and undoes any inversion. Both paths are registered and take one clock. Each data beat carries a valid strobe.

Two policies can be selected at run time. The zero-balancing policy looks only at the byte itself and flips it when it holds too many zeros. The transition-limiting policy compares each byte with the byte most recently driven on the same lane, and flips it when flipping cuts the number of toggling lines. In a configuration with several phases per controller clock, the later phases are compared in a chain within the cycle. The first phase is compared with the last phase of the previous beat. A global enable turns the whole block into a registered pass-through.

Top module: `dbi_codec`

## Requirements
- R1: Phase p, lane l of a data word occupies bits [(p*LANES+l)*8 +: 8], and its flag is bit p*LANES+l. A flag of 0 means the byte on the wire is the bitwise complement of the true byte. A flag of 1 means the byte is unchanged.
- R2: With the enable high and `ac_mode_i` low (zero-balancing), a write byte holding five or more zero bits is sent inverted. In that mode at least five of the nine lines of every lane (eight data bits and the flag) are high.
- R3: In zero-balancing mode, a byte with exactly four zero bits is sent unchanged with its flag high.
- R4: With the enable high and `ac_mode_i` high (transition-limiting), a byte is inverted exactly when more than four of its bits differ from the reference byte. Consecutive driven bytes on a lane therefore differ in at most four bits.
- R5: In transition-limiting mode, a byte that differs from its reference in exactly four bits is sent unchanged.
- R6: The reference for phase k>0 is the driven (encoded) byte of phase k-1 on the same lane in the same beat. The reference for phase 0 is the driven byte of the last phase of the most recent valid write beat, in either mode. Cycles with `wr_valid_i` low leave that history untouched.
- R7: With the enable high, each read byte whose flag is 0 is complemented and each byte whose flag is 1 is passed through. The result is aligned with the data it was received with.
- R8: With `en_i` low, write and read data pass through unchanged, and every write flag is driven high.
- R9: Every output is due one clock after its input: `wr_valid_o` and `rd_valid_o` equal the input strobes of the previous cycle, together with that beat's data and flags.
- R10: Reset clears both output strobes, drives all write flags high, and sets the transition history to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Global inversion enable; low selects pass-through |
| ac_mode_i | input | 1 | 0 selects zero-balancing, 1 selects transition-limiting |
| wr_valid_i | input | 1 | Write beat strobe |
| wr_data_i | input | PHASES*LANES*8 | Write data from the controller |
| wr_valid_o | output | 1 | Registered write beat strobe |
| wr_data_o | output | PHASES*LANES*8 | Possibly inverted write data toward the PHY |
| wr_dbi_n_o | output | PHASES*LANES | Active-low inversion flags, one per lane and phase |
| rd_valid_i | input | 1 | Read beat strobe |
| rd_data_i | input | PHASES*LANES*8 | Received read data |
| rd_dbi_n_i | input | PHASES*LANES | Received active-low inversion flags |
| rd_valid_o | output | 1 | Registered read beat strobe |
| rd_data_o | output | PHASES*LANES*8 | Restored read data |

## Verification
Both paths have a single register stage, so every flag, byte and strobe is due on the first rising edge after the inputs are applied. The bench changes inputs on a falling edge and reads results on the next falling edge, with exactly one rising edge in between. The transition history is the only state that lasts longer: the effect of one beat shows up in the phase-0 result of the next valid beat, however many idle cycles lie between them. The bench's reference model therefore advances its own history only on valid beats.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
    localparam int unsigned LANE_W = 8;

    typedef enum logic {
        MODE_DC = 1'b0,
        MODE_AC = 1'b1
    } dbi_mode_e;
endpackage

// File: rtl/dbi_lane_enc.sv
module dbi_lane_enc
    import dbi_pkg::*;
(
    input  logic [LANE_W-1:0] raw_i,
    input  logic [LANE_W-1:0] prev_i,
    input  dbi_mode_e         mode_i,
    input  logic              en_i,
    output logic [LANE_W-1:0] enc_o,
    output logic              dbi_n_o
);
    localparam int unsigned CW = $clog2(LANE_W + 1);
    localparam logic [CW-1:0] HALF = CW'(LANE_W / 2);

    logic [CW-1:0] zeros;
    logic [CW-1:0] toggles;
    logic          flip;

    always_comb begin
        zeros   = '0;
        toggles = '0;
        for (int i = 0; i < LANE_W; i++) begin
            zeros   += CW'(!raw_i[i]);
            toggles += CW'(raw_i[i] ^ prev_i[i]);
        end
        if (!en_i) begin
            flip = 1'b0;
        end else if (mode_i == MODE_AC) begin
            flip = toggles > HALF;   // tie at HALF keeps the byte
        end else begin
            flip = zeros > HALF;     // exactly HALF zeros keeps the byte
        end
    end

    assign enc_o   = flip ? ~raw_i : raw_i;
    assign dbi_n_o = ~flip;
endmodule

// File: rtl/dbi_wr_path.sv
module dbi_wr_path
    import dbi_pkg::*;
#(
    parameter int unsigned PHASES = 2,
    parameter int unsigned LANES  = 2
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic                              en_i,
    input  dbi_mode_e                         mode_i,
    input  logic                              valid_i,
    input  logic [PHASES*LANES*LANE_W-1:0]    data_i,
    output logic                              valid_o,
    output logic [PHASES*LANES*LANE_W-1:0]    data_o,
    output logic [PHASES*LANES-1:0]           dbi_n_o
);
    localparam int unsigned PW = LANES * LANE_W;
    localparam int unsigned DW = PHASES * PW;
    localparam int unsigned NB = PHASES * LANES;

    typedef struct packed {
        logic          valid;
        logic          en;
        logic          ac;
        logic [DW-1:0] data;
        logic [NB-1:0] dbi_n;
        logic [PW-1:0] hist;
    } wr_state_t;

    wr_state_t st_d, st_q;

    logic [DW-1:0] enc_all;
    logic [NB-1:0] dbi_all;

    for (genvar p = 0; p < PHASES; p++) begin : g_ph
        logic [PW-1:0]    prev_w;
        logic [PW-1:0]    enc_w;
        logic [LANES-1:0] dbi_w;

        if (p == 0) begin : g_first
            assign prev_w = st_q.hist;
        end else begin : g_next
            assign prev_w = g_ph[p-1].enc_w;
        end

        for (genvar l = 0; l < LANES; l++) begin : g_ln
            dbi_lane_enc u_enc (
                .raw_i   (data_i[(p*LANES+l)*LANE_W +: LANE_W]),
                .prev_i  (prev_w[l*LANE_W +: LANE_W]),
                .mode_i  (mode_i),
                .en_i    (en_i),
                .enc_o   (enc_w[l*LANE_W +: LANE_W]),
                .dbi_n_o (dbi_w[l])
            );
        end

        assign enc_all[p*PW +: PW]       = enc_w;
        assign dbi_all[p*LANES +: LANES] = dbi_w;
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = valid_i;
        st_d.en    = en_i;
        st_d.ac    = (mode_i == MODE_AC);
        st_d.data  = enc_all;
        st_d.dbi_n = dbi_all;
        if (valid_i) begin
            st_d.hist = g_ph[PHASES-1].enc_w;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{valid: 1'b0, en: 1'b0, ac: 1'b0, data: '0, dbi_n: '1, hist: '1};
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign data_o  = st_q.data;
    assign dbi_n_o = st_q.dbi_n;

    for (genvar p = 0; p < PHASES; p++) begin : g_chk_ph
        for (genvar l = 0; l < LANES; l++) begin : g_chk_ln
            localparam int unsigned B = (p * LANES + l) * LANE_W;

            p_dc_ones_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (st_q.valid && st_q.en && !st_q.ac)
                |-> ($countones({data_o[B +: LANE_W], dbi_n_o[p*LANES+l]}) >= 5));

            if (p > 0) begin : g_ac
                p_ac_toggle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
                    (st_q.valid && st_q.en && st_q.ac)
                    |-> ($countones(data_o[B +: LANE_W] ^ data_o[B-PW +: LANE_W]) <= LANE_W/2));
            end
        end
    end

    p_wr_bypass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.valid && !st_q.en) |-> (&dbi_n_o));

    p_wr_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> $past(valid_i));
endmodule

// File: rtl/dbi_rd_path.sv
module dbi_rd_path
    import dbi_pkg::*;
#(
    parameter int unsigned PHASES = 2,
    parameter int unsigned LANES  = 2
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic                              en_i,
    input  logic                              valid_i,
    input  logic [PHASES*LANES*LANE_W-1:0]    data_i,
    input  logic [PHASES*LANES-1:0]           dbi_n_i,
    output logic                              valid_o,
    output logic [PHASES*LANES*LANE_W-1:0]    data_o
);
    localparam int unsigned NB = PHASES * LANES;
    localparam int unsigned DW = NB * LANE_W;

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
    } rd_state_t;

    rd_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = valid_i;
        for (int i = 0; i < NB; i++) begin
            if (en_i && !dbi_n_i[i]) begin
                st_d.data[i*LANE_W +: LANE_W] = ~data_i[i*LANE_W +: LANE_W];
            end else begin
                st_d.data[i*LANE_W +: LANE_W] = data_i[i*LANE_W +: LANE_W];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{valid: 1'b0, data: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign data_o  = st_q.data;

    p_rd_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> $past(valid_i));

    p_rd_plain_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && (&$past(dbi_n_i))) |-> (data_o == $past(data_i)));
endmodule

// File: rtl/dbi_codec.sv
module dbi_codec
    import dbi_pkg::*;
#(
    parameter int unsigned PHASES = 2,
    parameter int unsigned LANES  = 2
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic                              en_i,
    input  logic                              ac_mode_i,
    input  logic                              wr_valid_i,
    input  logic [PHASES*LANES*LANE_W-1:0]    wr_data_i,
    output logic                              wr_valid_o,
    output logic [PHASES*LANES*LANE_W-1:0]    wr_data_o,
    output logic [PHASES*LANES-1:0]           wr_dbi_n_o,
    input  logic                              rd_valid_i,
    input  logic [PHASES*LANES*LANE_W-1:0]    rd_data_i,
    input  logic [PHASES*LANES-1:0]           rd_dbi_n_i,
    output logic                              rd_valid_o,
    output logic [PHASES*LANES*LANE_W-1:0]    rd_data_o
);
    dbi_mode_e mode;
    assign mode = ac_mode_i ? MODE_AC : MODE_DC;

    dbi_wr_path #(.PHASES(PHASES), .LANES(LANES)) u_wr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (en_i),
        .mode_i  (mode),
        .valid_i (wr_valid_i),
        .data_i  (wr_data_i),
        .valid_o (wr_valid_o),
        .data_o  (wr_data_o),
        .dbi_n_o (wr_dbi_n_o)
    );

    dbi_rd_path #(.PHASES(PHASES), .LANES(LANES)) u_rd (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (en_i),
        .valid_i (rd_valid_i),
        .data_i  (rd_data_i),
        .dbi_n_i (rd_dbi_n_i),
        .valid_o (rd_valid_o),
        .data_o  (rd_data_o)
    );
endmodule

// File: tb/tb_dbi_codec.sv
module tb_dbi_codec;
    localparam int PH = 2;
    localparam int LN = 2;
    localparam int NB = PH * LN;
    localparam int PW = LN * 8;
    localparam int DW = PH * PW;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic          en    = 1'b1;
    logic          ac    = 1'b0;
    logic          wv    = 1'b0;
    logic [DW-1:0] wd    = '0;
    logic          wvo;
    logic [DW-1:0] wdo;
    logic [NB-1:0] wdbo;
    logic          rv    = 1'b0;
    logic [DW-1:0] rdd   = '0;
    logic [NB-1:0] rdb   = '1;
    logic          rvo;
    logic [DW-1:0] rdo;

    int            n_chk  = 0;
    int            n_fail = 0;
    bit            done   = 1'b0;
    logic [PW-1:0] m_hist = '1;
    logic [31:0]   rng    = 32'h1ACE_B00C;

    always #10 clk = ~clk;

    dbi_codec #(.PHASES(PH), .LANES(LN)) dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .en_i       (en),
        .ac_mode_i  (ac),
        .wr_valid_i (wv),
        .wr_data_i  (wd),
        .wr_valid_o (wvo),
        .wr_data_o  (wdo),
        .wr_dbi_n_o (wdbo),
        .rd_valid_i (rv),
        .rd_data_i  (rdd),
        .rd_dbi_n_i (rdb),
        .rd_valid_o (rvo),
        .rd_data_o  (rdo)
    );

    function automatic int pc8(logic [7:0] x);
        int c;
        c = 0;
        for (int i = 0; i < 8; i++) c += int'(x[i]);
        return c;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step();
        rng ^= rng << 13;
        rng ^= rng >> 17;
        rng ^= rng << 5;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wv    = 1'b0;
        rv    = 1'b0;
        repeat (2) @(negedge clk);
        m_hist = '1;
        chk("R10 wr valid after reset", wvo, 0);
        chk("R10 rd valid after reset", rvo, 0);
        chk("R10 flags after reset", wdbo, {NB{1'b1}});
        rst_n = 1'b1;
    endtask

    // Drive one write cycle; the model below follows R1-style mapping and the mode rules.
    task automatic wr_beat(input logic v, input logic [DW-1:0] d);
        logic [DW-1:0] ed;
        logic [NB-1:0] eb;
        logic [PW-1:0] prev;
        string         tg [NB];
        prev = m_hist;
        for (int p = 0; p < PH; p++) begin
            for (int l = 0; l < LN; l++) begin
                int         idx;
                int         t;
                int         z;
                logic       inv;
                logic [7:0] x;
                idx = p * LN + l;
                x   = d[idx*8 +: 8];
                t   = pc8(x ^ prev[l*8 +: 8]);
                z   = 8 - pc8(x);
                if (!en) begin
                    inv = 1'b0;
                    tg[idx] = "R8";
                end else if (ac) begin
                    inv = (t > 4);
                    tg[idx] = (t == 4) ? "R5" : ((p == 0) ? "R6" : "R4");
                end else begin
                    inv = (z > 4);
                    tg[idx] = (z == 4) ? "R3" : "R2";
                end
                ed[idx*8 +: 8] = inv ? ~x : x;
                eb[idx]        = ~inv;
            end
            prev = ed[p*PW +: PW];
        end
        if (v) m_hist = prev;
        wv = v;
        wd = d;
        @(negedge clk);
        chk("R9 wr valid", wvo, v);
        if (v) begin
            for (int i = 0; i < NB; i++) begin
                chk({tg[i], " R1 write data"}, wdo[i*8 +: 8], ed[i*8 +: 8]);
                chk({tg[i], " R1 write flag"}, wdbo[i], eb[i]);
            end
        end
    endtask

    task automatic rd_beat(input logic v, input logic [DW-1:0] d, input logic [NB-1:0] b);
        rv  = v;
        rdd = d;
        rdb = b;
        @(negedge clk);
        chk("R9 rd valid", rvo, v);
        if (v) begin
            for (int i = 0; i < NB; i++) begin
                logic [7:0] e;
                e = (en && !b[i]) ? ~d[i*8 +: 8] : d[i*8 +: 8];
                chk(en ? "R7 read data" : "R8 read data", rdo[i*8 +: 8], e);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        summary();
    end

    initial begin
        do_reset();

        // Zero-balancing sweep: lane 0 walks all 256 bytes.
        en = 1'b1;
        ac = 1'b0;
        for (int v = 0; v < 256; v++) begin
            logic [7:0] b;
            b = 8'(v);
            if (v % 16 == 15) begin
                step();
                wr_beat(1'b0, rng);
            end
            wr_beat(1'b1, {b ^ 8'h5A, {b[3:0], b[7:4]}, ~b, b});
        end

        // Transition-limiting: directed ties and full flips after reset.
        ac = 1'b1;
        do_reset();
        wr_beat(1'b1, 32'hF0F0_0F0F);
        do_reset();
        wr_beat(1'b1, 32'h0000_0000);
        wr_beat(1'b1, 32'hFFFF_FFFF);

        // Transition-limiting with idle cycles that carry junk data.
        for (int k = 0; k < 400; k++) begin
            step();
            wr_beat(rng[3:0] != 4'h0, rng);
        end

        // Mode changes between beats keep the history chain.
        for (int k = 0; k < 100; k++) begin
            step();
            ac = rng[5];
            wr_beat(1'b1, rng);
        end

        // Bypass on the write path, then re-enable.
        en = 1'b0;
        for (int k = 0; k < 40; k++) begin
            step();
            ac = rng[7];
            wr_beat(1'b1, rng);
        end
        en = 1'b1;
        ac = 1'b1;
        for (int k = 0; k < 20; k++) begin
            step();
            wr_beat(1'b1, rng);
        end
        wr_beat(1'b0, '0);

        // Read path: every flag combination across a byte sweep.
        for (int v = 0; v < 256; v++) begin
            logic [7:0] b;
            b = 8'(v);
            if (v % 32 == 31) rd_beat(1'b0, {4{b}}, 4'h0);
            rd_beat(1'b1, {b, ~b, b ^ 8'hA5, {b[0], b[7:1]}}, b[3:0] ^ b[7:4]);
        end
        en = 1'b0;
        for (int k = 0; k < 20; k++) begin
            step();
            rd_beat(1'b1, rng, rng[11:8]);
        end
        rd_beat(1'b0, '0, '1);

        summary();
    end
endmodule